// File: doc/BRIEF.md
# Arbiter Preemption Delay Timer

This block tells a secondary-bus arbiter when it is allowed to take the grant away from the master that currently owns the bus. A tenure begins in the cycle where the frame indication goes from low to high. From that cycle on, the block counts a programmable number of clocks and then raises a preemption-enable level. The arbiter combines this level with its own request logic to decide whether to preempt.

The delay comes from a 4-bit control code. When the top bit is set, preemption is switched off for the whole tenure. Otherwise the low three bits select the delay. A value of zero gives an immediate enable, and each higher value doubles the delay, starting at one cycle and ending at sixty-four. The code is sampled only when a tenure starts. Once the enable is high it stays high until the bus goes idle. An idle bus clears the count and drops the enable.

Top module: `apd_preempt_timer`

## Requirements
- R1: After reset, with frame low and the bus not idle, preempt_en_o is 0.
- R2: If bit 3 of the code sampled at a frame rise is 1, preempt_en_o stays 0 for that whole tenure, whatever bits 2:0 hold.
- R3: With code 4'b0000 sampled at a frame rise, preempt_en_o is 1 in that same cycle (a combinational path from frame_i).
- R4: With code 4'b0001, preempt_en_o goes to 1 exactly one cycle after the frame-rise cycle.
- R5: With bits 2:0 of the code equal to k, where k is from 2 to 7, preempt_en_o is 0 for the first 2^(k-1) cycles, counting the frame-rise cycle as cycle 0. It goes to 1 in cycle 2^(k-1).
- R6: Once preempt_en_o is 1, it stays 1 until bus_idle_i is high or a new frame rise occurs. A drop of frame_i alone does not clear it.
- R7: While bus_idle_i is 1, preempt_en_o is 0 and any count in progress is discarded. Idle takes priority over a frame rise in the same cycle.
- R8: A change of delay_code_i after the frame rise has no effect on the current tenure. The new code takes effect at the next frame rise.
- R9: A new frame rise without an intervening idle cycle ends the current tenure and restarts timing with the code present at that rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| delay_code_i | input | 4 | Bit 3 disables preemption; bits 2:0 select the delay (0, 1, 2, 4 ... 64 cycles) |
| frame_i | input | 1 | Frame is asserted by the current master (level) |
| bus_idle_i | input | 1 | Bus has returned to idle |
| preempt_en_o | output | 1 | Preemption allowed for the current tenure |

## Verification
The bench targets the off-by-one boundary of every delay. A design that counts from the wrong cycle would raise the enable one clock early or late, and the reference catches that slip for each code from zero to seven. It also changes the code in the middle of a tenure: a design that reads the live code would shorten, lengthen or cancel a count already under way. It re-raises frame without an idle cycle, where a design that fails to reload would keep a stale enable. It drives idle together with a frame rise, where a design with the wrong priority would start a tenure that should not exist.

// File: rtl/apd_pkg.sv
package apd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2,
    ST_OFF  = 2'd3
  } apd_state_e;
endpackage

// File: rtl/apd_edge_detect.sv
module apd_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/apd_code_decode.sv
module apd_code_decode #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 7
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              off_o,
  output logic              zero_o,
  output logic              short_o,
  output logic [CNT_W-1:0]  load_val_o
);
  localparam int SHIFT_W = CODE_W - 1;

  logic [SHIFT_W-1:0] shift;
  logic [CNT_W-1:0]   delay;

  assign shift   = code_i[SHIFT_W-1:0];
  assign off_o   = code_i[CODE_W-1];
  assign zero_o  = (shift == '0);
  assign short_o = (shift <= SHIFT_W'(1));

  // delay = 2^(shift-1); counter is loaded with delay-1
  always_comb begin
    delay = '0;
    if (!short_o) delay = {{(CNT_W-1){1'b0}}, 1'b1} << (shift - SHIFT_W'(1));
  end

  assign load_val_o = short_o ? '0 : (delay - {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/apd_countdown.sv
module apd_countdown #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clear_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign hit_o = run_q && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b1;
    end else if (clear_i || hit_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
  import apd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic idle_i,
  input  logic off_i,
  input  logic zero_i,
  input  logic short_i,
  input  logic hit_i,
  output logic load_o,
  output logic clear_o,
  output logic en_o
);
  apd_state_e state_q, state_d;
  logic       start;

  assign start   = rise_i & ~idle_i;
  assign load_o  = start & ~off_i & ~short_i;
  assign clear_o = idle_i | (rise_i & ~load_o);

  always_comb begin
    state_d = state_q;
    if (idle_i) begin
      state_d = ST_IDLE;
    end else if (rise_i) begin
      if (off_i)        state_d = ST_OFF;
      else if (short_i) state_d = ST_ON;
      else              state_d = ST_WAIT;
    end else if (state_q == ST_WAIT && hit_i) begin
      state_d = ST_ON;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // zero-delay code enables in the rise cycle itself
  assign en_o = (state_q == ST_ON && !rise_i && !idle_i) | (start & ~off_i & zero_i);
endmodule

// File: rtl/apd_preempt_timer.sv
module apd_preempt_timer #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] delay_code_i,
  input  logic              frame_i,
  input  logic              bus_idle_i,
  output logic              preempt_en_o
);
  localparam int MAX_EXP = (2 ** (CODE_W - 1)) - 2;
  localparam int CNT_W   = MAX_EXP + 1;

  logic             rise, off, zero, short_dly, hit, load, clear;
  logic [CNT_W-1:0] load_val;

  apd_edge_detect u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (frame_i),
    .rise_o (rise)
  );

  apd_code_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
    .code_i     (delay_code_i),
    .off_o      (off),
    .zero_o     (zero),
    .short_o    (short_dly),
    .load_val_o (load_val)
  );

  apd_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .clear_i    (clear),
    .hit_o      (hit)
  );

  apd_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .idle_i  (bus_idle_i),
    .off_i   (off),
    .zero_i  (zero),
    .short_i (short_dly),
    .hit_i   (hit),
    .load_o  (load),
    .clear_o (clear),
    .en_o    (preempt_en_o)
  );
endmodule

// File: rtl/apd_preempt_timer_chk.sv
module apd_preempt_timer_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] delay_code_i,
  input logic              frame_i,
  input logic              bus_idle_i,
  input logic              preempt_en_o
);
  logic frame_q, dis_q, rise;

  assign rise = frame_i && !frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      dis_q   <= 1'b0;
    end else begin
      frame_q <= frame_i;
      if (bus_idle_i)  dis_q <= 1'b0;
      else if (rise)   dis_q <= delay_code_i[CODE_W-1];
    end
  end

  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle_i |-> !preempt_en_o);

  a_r2_off_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !bus_idle_i && delay_code_i[CODE_W-1]) |-> !preempt_en_o);

  a_r2_off_tenure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_q && !rise) |-> !preempt_en_o);

  a_r3_zero_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !bus_idle_i && delay_code_i == '0) |-> preempt_en_o);

  a_r4_one_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !bus_idle_i && delay_code_i == CODE_W'(1)) |-> !preempt_en_o);

  a_r4_one_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !bus_idle_i && delay_code_i == CODE_W'(1)) |=> (preempt_en_o || bus_idle_i));

  a_r5_not_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !bus_idle_i && !delay_code_i[CODE_W-1] && delay_code_i[CODE_W-2:0] >= 3'd2)
      |=> (!preempt_en_o || rise));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preempt_en_o && !bus_idle_i) |=> (preempt_en_o || bus_idle_i || rise));
endmodule

bind apd_preempt_timer apd_preempt_timer_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_apd_preempt_timer.sv
`timescale 1ns/100ps
module tb_apd_preempt_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] delay_code_i = 4'd0;
  logic       frame_i = 1'b0;
  logic       bus_idle_i = 1'b1;
  logic       preempt_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit         m_frame_q = 0, m_active = 0, m_dis = 0;
  int         m_start = 0, m_delay = 0, cyc = 0;
  bit         p_frame = 0, p_idle = 1;
  logic [3:0] p_code = 0;

  always #2.5 clk_i = ~clk_i;

  apd_preempt_timer dut (.*);

  function automatic int dly_of(logic [3:0] c);
    if (c[2:0] == 3'd0) return 0;
    return 1 << (c[2:0] - 1);
  endfunction

  task automatic check(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  task automatic step(bit fr, bit idl, logic [3:0] code);
    bit rise, exp;
    string req;
    @(posedge clk_i);
    // advance model with inputs seen at this edge
    if (p_idle) m_active = 0;
    else if (p_frame && !m_frame_q) begin
      m_active = 1; m_dis = p_code[3]; m_delay = dly_of(p_code); m_start = cyc;
    end
    m_frame_q = p_frame;
    cyc++;
    #1;
    frame_i = fr; bus_idle_i = idl; delay_code_i = code;
    p_frame = fr; p_idle = idl; p_code = code;
    #2;
    rise = fr && !m_frame_q;
    if (idl) begin exp = 0; req = "R7"; end
    else if (rise) begin
      exp = !code[3] && code[2:0] == 3'd0;
      req = code[3] ? "R2" : (code[2:0] == 0) ? "R3" : (code[2:0] == 1) ? "R4" : "R5";
    end else if (!m_active) begin exp = 0; req = "R7"; end
    else if (m_dis) begin exp = 0; req = "R2"; end
    else begin
      exp = (cyc - m_start) >= m_delay;
      if ((cyc - m_start) > m_delay) req = "R6";
      else req = (m_delay == 0) ? "R3" : (m_delay == 1) ? "R4" : "R5";
    end
    check(preempt_en_o, exp, req);
  endtask

  task automatic tenure(logic [3:0] code, int len, bit mid_change);
    step(1'b1, 1'b0, code);
    for (int i = 0; i < len; i++)
      step((i < len - 2), 1'b0, mid_change ? 4'($urandom) : code);
  endtask

  initial begin
    void'($urandom(32'h5eed_a9d1));
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    bus_idle_i = 1'b0; p_idle = 0;
    #1 check(preempt_en_o, 1'b0, "R1");
    step(1'b0, 1'b1, 4'd0);

    // directed: every code, long enough to see the enable
    for (int c = 0; c < 16; c++) begin
      tenure(4'(c), 70, 0);
      step(1'b0, 1'b1, 4'(c));
    end
    // R8: code changes mid-count have no effect
    tenure(4'd7, 70, 1);
    step(1'b0, 1'b1, 4'd0);
    tenure(4'd8, 20, 1);
    step(1'b0, 1'b1, 4'd0);
    // R9: re-raise frame without idle, new code applies
    step(1'b1, 1'b0, 4'd0);
    step(1'b1, 1'b0, 4'd0);
    step(1'b0, 1'b0, 4'd5);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 4'd0);
    step(1'b0, 1'b1, 4'd0);
    // R7: idle together with a frame rise starts nothing
    step(1'b1, 1'b1, 4'd0);
    step(1'b1, 1'b0, 4'd0);
    check(preempt_en_o, 1'b0, "R7 after idle-with-rise");
    step(1'b0, 1'b1, 4'd0);
    // R6: frame drops but not idle, enable holds
    step(1'b1, 1'b0, 4'd2);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 4'd0);
    step(1'b0, 1'b1, 4'd0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b1, 4'($urandom));
      if ($urandom_range(0, 4) == 0)
        step(1'b0, 1'b0, 4'($urandom));
      tenure(4'($urandom), $urandom_range(1, 80), $urandom_range(0, 2) == 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule